// File: doc/BRIEF.md
# Serial-Port GPIO Pin Multiplexer

This block is an eight-pin general-purpose I/O port whose pins may be taken over by one SPI peripheral and two UART-style serial peripherals (called SCI1 and SCI0 here). Software reaches it through a small synchronous register bus. The bus exposes a data latch, a direction register and a read-only view of the pin levels. For every pin the block drives an output value and an output enable towards the pad ring. Each of these comes either from the GPIO registers or from the peripheral that currently owns the pin.

Ownership is decided per pin group and is fixed. The upper four pins belong to the SPI when it is enabled. Pins 3 and 2 belong to SCI1 when it is enabled, and pins 1 and 0 belong to SCI0. An owned pin ignores the GPIO direction and data bits for driving purposes. The data latch can still be written while a pin is owned, so the written level appears on the pin once the peripheral lets the pin go. Pin levels pass through a two-stage synchronizer before software can read them.

Top module: `serial_pin_mux`

## Requirements
- R1: After reset the data latch and the direction register both hold 0x00 and every pad output enable is 0.
- R2: The data register is at address 0x8 and can be written at any time. A read returns the latched bit for every pin whose direction bit is 1.
- R3: For every pin whose direction bit is 0, a read of address 0x8 returns the pin level seen through two clock stages. A pin change therefore becomes visible after the second rising edge, and not after the first.
- R4: Address 0x9 always returns the synchronized pin levels, whatever the direction bits are. Writes to 0x9 change no register.
- R5: The direction register is at address 0x2 and can be read and written. While no peripheral owns a pin, the pad output enable equals the pin's direction bit and the pad output equals its data latch bit.
- R6: With the SPI enabled, pins 7, 6, 5 and 4 carry SS, SCK, MOSI and MISO in that order. In master mode pins 7 to 5 are driven and pin 4 is not. In slave mode only pin 4 is driven.
- R7: With SCI1 enabled, pin 3 is always driven with the SCI1 transmit value and pin 2 (receive) is never driven.
- R8: With SCI0 enabled, pin 1 is always driven with the SCI0 transmit value and pin 0 (receive) is never driven.
- R9: A data write made while a peripheral owns a pin updates the latch. After the peripheral is disabled the pin drives the written value.
- R10: Reads from any address other than 0x2, 0x8 and 0x9 return 0x00, and writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Register address |
| busWe | input | 1 | Write enable, sampled on the rising edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the current address (combinational) |
| spiEn | input | 1 | SPI takes pins 7..4 |
| spiMaster | input | 1 | 1 = SPI master, 0 = slave |
| spiSsOut | input | 1 | SPI SS output value |
| spiSckOut | input | 1 | SPI clock output value |
| spiMosiOut | input | 1 | SPI MOSI output value |
| spiMisoOut | input | 1 | SPI MISO output value |
| sci1En | input | 1 | SCI1 takes pins 3..2 |
| sci1TxOut | input | 1 | SCI1 transmit value |
| sci0En | input | 1 | SCI0 takes pins 1..0 |
| sci0TxOut | input | 1 | SCI0 transmit value |
| padIn | input | 8 | Pin levels from the pads |
| padOut | output | 8 | Per-pin output value |
| padOe | output | 8 | Per-pin output enable |

## Verification
On every cycle the assertions check the pad enables and values that each enabled peripheral imposes on its pin group in both SPI modes. They also check that a data write is captured on the next edge and that a bus write to the input or to an unmapped address never turns into a register strobe. Other behaviour can only be shown by the bench scenarios: the two-edge synchronizer latency, the per-bit mix of latch and pin in a data read, a latch value that comes out once ownership ends, and the reset state.

// File: rtl/spm_pkg.sv
package spm_pkg;
  parameter int unsigned PORT_W = 8;
  parameter int unsigned ADDR_W = 4;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdInput;
    logic rdDir;
  } regStrobe_t;
endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int unsigned AW        = ADDR_W,
  parameter logic [AW-1:0] DIR_ADDR   = 4'h2,
  parameter logic [AW-1:0] DATA_ADDR  = 4'h8,
  parameter logic [AW-1:0] INPUT_ADDR = 4'h9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  output regStrobe_t    stb
);
  logic hitData, hitDir, hitInput;

  always_comb begin
    hitData  = (busAddr == DATA_ADDR);
    hitDir   = (busAddr == DIR_ADDR);
    hitInput = (busAddr == INPUT_ADDR);
    stb.wrData  = busWe & hitData;
    stb.wrDir   = busWe & hitDir;
    stb.rdData  = hitData;
    stb.rdDir   = hitDir;
    stb.rdInput = hitInput;
  end

  // R4
  input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == INPUT_ADDR) |-> (!stb.wrData && !stb.wrDir));

  // R10
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr != DATA_ADDR && busAddr != DIR_ADDR) |-> (!stb.wrData && !stb.wrDir));
endmodule

// File: rtl/spm_datapath.sv
module spm_datapath
  import spm_pkg::*;
#(
  parameter int unsigned W         = PORT_W,
  parameter int unsigned SPI_BASE  = 4,
  parameter int unsigned SCI1_BASE = 2,
  parameter int unsigned SCI0_BASE = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  regStrobe_t   stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] padIn,
  input  logic         spiEn,
  input  logic         spiMaster,
  input  logic         spiSsOut,
  input  logic         spiSckOut,
  input  logic         spiMosiOut,
  input  logic         spiMisoOut,
  input  logic         sci1En,
  input  logic         sci1TxOut,
  input  logic         sci0En,
  input  logic         sci0TxOut,
  output logic [W-1:0] rdata,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe
);
  localparam int unsigned SPI_SS   = SPI_BASE + 3;
  localparam int unsigned SPI_SCK  = SPI_BASE + 2;
  localparam int unsigned SPI_MOSI = SPI_BASE + 1;
  localparam int unsigned SPI_MISO = SPI_BASE;
  localparam int unsigned SCI1_TX  = SCI1_BASE + 1;
  localparam int unsigned SCI1_RX  = SCI1_BASE;
  localparam int unsigned SCI0_TX  = SCI0_BASE + 1;
  localparam int unsigned SCI0_RX  = SCI0_BASE;

  logic [W-1:0] dataReg, dirReg;
  logic [W-1:0] syncA, syncB;
  logic [W-1:0] periOwn, periOut, periOe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
    end else begin
      if (stb.wrData) dataReg <= wdata;
      if (stb.wrDir)  dirReg  <= wdata;
    end
  end

  // pin synchronizer, deliberately left out of reset
  always_ff @(posedge clk) begin
    syncA <= padIn;
    syncB <= syncA;
  end

  always_comb begin
    periOwn = '0;
    periOut = '0;
    periOe  = '0;
    if (spiEn) begin
      periOwn[SPI_SS]   = 1'b1;
      periOwn[SPI_SCK]  = 1'b1;
      periOwn[SPI_MOSI] = 1'b1;
      periOwn[SPI_MISO] = 1'b1;
      periOut[SPI_SS]   = spiSsOut;
      periOut[SPI_SCK]  = spiSckOut;
      periOut[SPI_MOSI] = spiMosiOut;
      periOut[SPI_MISO] = spiMisoOut;
      periOe[SPI_SS]    = spiMaster;
      periOe[SPI_SCK]   = spiMaster;
      periOe[SPI_MOSI]  = spiMaster;
      periOe[SPI_MISO]  = ~spiMaster;
    end
    if (sci1En) begin
      periOwn[SCI1_TX] = 1'b1;
      periOwn[SCI1_RX] = 1'b1;
      periOut[SCI1_TX] = sci1TxOut;
      periOe[SCI1_TX]  = 1'b1;
    end
    if (sci0En) begin
      periOwn[SCI0_TX] = 1'b1;
      periOwn[SCI0_RX] = 1'b1;
      periOut[SCI0_TX] = sci0TxOut;
      periOe[SCI0_TX]  = 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : gPin
    assign padOut[i] = periOwn[i] ? periOut[i] : dataReg[i];
    assign padOe[i]  = periOwn[i] ? periOe[i]  : dirReg[i];
  end

  always_comb begin
    if (stb.rdData)       rdata = (dataReg & dirReg) | (syncB & ~dirReg);
    else if (stb.rdInput) rdata = syncB;
    else if (stb.rdDir)   rdata = dirReg;
    else                  rdata = '0;
  end

  // R2
  data_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrData |=> (dataReg == $past(wdata)));

  // R6
  spi_master_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && spiMaster) |-> (padOe[SPI_SS] && padOe[SPI_SCK] && padOe[SPI_MOSI]
                              && !padOe[SPI_MISO] && padOut[SPI_SCK] == spiSckOut));

  // R6
  spi_slave_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && !spiMaster) |-> (!padOe[SPI_SS] && !padOe[SPI_SCK] && !padOe[SPI_MOSI]
                               && padOe[SPI_MISO] && padOut[SPI_MISO] == spiMisoOut));

  // R7
  sci1_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    sci1En |-> (padOe[SCI1_TX] && !padOe[SCI1_RX] && padOut[SCI1_TX] == sci1TxOut));

  // R8
  sci0_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    sci0En |-> (padOe[SCI0_TX] && !padOe[SCI0_RX] && padOut[SCI0_TX] == sci0TxOut));
endmodule

// File: rtl/serial_pin_mux.sv
module serial_pin_mux
  import spm_pkg::*;
#(
  parameter int unsigned W  = PORT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic [W-1:0]  busWdata,
  output logic [W-1:0]  busRdata,
  input  logic          spiEn,
  input  logic          spiMaster,
  input  logic          spiSsOut,
  input  logic          spiSckOut,
  input  logic          spiMosiOut,
  input  logic          spiMisoOut,
  input  logic          sci1En,
  input  logic          sci1TxOut,
  input  logic          sci0En,
  input  logic          sci0TxOut,
  input  logic [W-1:0]  padIn,
  output logic [W-1:0]  padOut,
  output logic [W-1:0]  padOe
);
  regStrobe_t stb;

  spm_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .stb(stb)
  );

  spm_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .padIn(padIn),
    .spiEn(spiEn), .spiMaster(spiMaster), .spiSsOut(spiSsOut),
    .spiSckOut(spiSckOut), .spiMosiOut(spiMosiOut), .spiMisoOut(spiMisoOut),
    .sci1En(sci1En), .sci1TxOut(sci1TxOut), .sci0En(sci0En), .sci0TxOut(sci0TxOut),
    .rdata(busRdata), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/serial_pin_mux_tb.sv
module serial_pin_mux_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] busAddr;
  logic       busWe;
  logic [7:0] busWdata, busRdata;
  logic spiEn, spiMaster, spiSsOut, spiSckOut, spiMosiOut, spiMisoOut;
  logic sci1En, sci1TxOut, sci0En, sci0TxOut;
  logic [7:0] padIn, padOut, padOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  serial_pin_mux u_dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic settle2();
    @(posedge clk); @(posedge clk);
  endtask

  task automatic testReset();
    logic [7:0] r;
    check("R1 oe", padOe, 8'h00);
    busRead(4'h2, r); check("R1 dir", r, 8'h00);
    busWrite(4'h2, 8'hFF);
    busRead(4'h8, r); check("R1 data", r, 8'h00);
    busWrite(4'h2, 8'h00);
  endtask

  task automatic testDataOut();
    logic [7:0] r;
    busWrite(4'h2, 8'hFF);
    busWrite(4'h8, 8'h96);
    busRead(4'h8, r); check("R2 read", r, 8'h96);
    check("R5 padOut", padOut, 8'h96);
    check("R5 padOe", padOe, 8'hFF);
    busRead(4'h2, r); check("R5 dir", r, 8'hFF);
  endtask

  task automatic testDataIn();
    logic [7:0] r;
    busWrite(4'h2, 8'h0F);
    busWrite(4'h8, 8'h33);
    @(negedge clk); padIn = 8'hC5;
    settle2();
    busRead(4'h8, r); check("R3 mixed", r, 8'hC3);
    check("R5 partial oe", padOe, 8'h0F);
    padIn = 8'h00;
    @(posedge clk);
    #1 check("R3 one edge", busRdata, 8'hC3);
    @(posedge clk);
    #1 check("R3 two edges", busRdata, 8'h03);
  endtask

  task automatic testInputReg();
    logic [7:0] r;
    busWrite(4'h2, 8'hFF);
    @(negedge clk); padIn = 8'h5A;
    settle2();
    busRead(4'h9, r); check("R4 pins", r, 8'h5A);
    busWrite(4'h9, 8'hFF);
    busRead(4'h9, r); check("R4 after write", r, 8'h5A);
    busRead(4'h2, r); check("R4 dir kept", r, 8'hFF);
    busRead(4'h8, r); check("R4 data kept", r, 8'h33);
  endtask

  task automatic testUnmapped();
    logic [7:0] r;
    busWrite(4'h0, 8'hAA);
    busWrite(4'hF, 8'h55);
    busRead(4'h0, r); check("R10 read", r, 8'h00);
    busRead(4'h2, r); check("R10 dir", r, 8'hFF);
    busRead(4'h8, r); check("R10 data", r, 8'h33);
  endtask

  task automatic testSpi();
    busWrite(4'h2, 8'h00);
    @(negedge clk);
    spiEn = 1'b1; spiMaster = 1'b1;
    spiSsOut = 1'b1; spiSckOut = 1'b0; spiMosiOut = 1'b1; spiMisoOut = 1'b1;
    #1;
    check("R6 master oe", padOe, 8'hE0);
    check("R6 master out", {padOut[7:4], 4'h0}, 8'hB0);
    spiMaster = 1'b0;
    #1;
    check("R6 slave oe", padOe, 8'h10);
    check("R6 slave miso", {7'h0, padOut[4]}, 8'h01);
    spiEn = 1'b0;
  endtask

  task automatic testSci();
    @(negedge clk);
    busWrite(4'h2, 8'h05);
    busWrite(4'h8, 8'h00);
    @(negedge clk);
    sci1En = 1'b1; sci1TxOut = 1'b1;
    #1;
    check("R7 oe", padOe, 8'h09);
    check("R7 tx", {7'h0, padOut[3]}, 8'h01);
    sci1En = 1'b0;
    sci0En = 1'b1; sci0TxOut = 1'b0;
    #1;
    check("R8 oe", padOe, 8'h06);
    check("R8 tx", {7'h0, padOut[1]}, 8'h00);
    sci0TxOut = 1'b1;
    #1 check("R8 tx hi", {7'h0, padOut[1]}, 8'h01);
    sci0En = 1'b0;
  endtask

  task automatic testLatchOwned();
    logic [7:0] r;
    busWrite(4'h2, 8'hF0);
    @(negedge clk);
    spiEn = 1'b1; spiMaster = 1'b1;
    spiSsOut = 1'b0; spiSckOut = 1'b0; spiMosiOut = 1'b0; spiMisoOut = 1'b0;
    busWrite(4'h8, 8'hA0);
    check("R9 owned out", {padOut[7:4], 4'h0}, 8'h00);
    busRead(4'h8, r); check("R9 latch", r & 8'hF0, 8'hA0);
    spiEn = 1'b0;
    #1;
    check("R9 released out", {padOut[7:4], 4'h0}, 8'hA0);
    check("R9 released oe", padOe, 8'hF0);
  endtask

  initial begin
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0; padIn = '0;
    spiEn = 0; spiMaster = 0; spiSsOut = 0; spiSckOut = 0; spiMosiOut = 0; spiMisoOut = 0;
    sci1En = 0; sci1TxOut = 0; sci0En = 0; sci0TxOut = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDataOut();
    testDataIn();
    testInputReg();
    testUnmapped();
    testSpi();
    testSci();
    testLatchOwned();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule